// File: doc/BRIEF.md
# Externally Clocked Edge Counter

This block is an up-counter whose count events come from an asynchronous trigger pin instead of the internal clock. The pin is brought into the internal clock domain by a two-flop synchronizer, optionally cleaned by a digital glitch filter, and passed through a polarity select. An edge detector then fires one internal-clock-wide pulse for each qualifying edge. A prescaler divides these pulses before they reach the counter.

All settings are plain input ports: filter length, prescale code, edge polarity, an enable for the external clock path and a separate run enable for the counter. Each count update lags the pin edge by a fixed and known number of internal clocks. The counter value is the only output.

Top module: `ext_edge_counter`

## Requirements
- R1: While `rst_n` is low the count is 0, and it stays 0 until a qualifying edge is counted.
- R2: With `edge_inv` at 0 only low-to-high pin transitions qualify. With `edge_inv` at 1 only high-to-low transitions qualify.
- R3: `psc_sel` codes 0, 1, 2 and 3 make the count advance once every 1, 2, 4 and 8 qualifying edges.
- R4: While `xclk_en` is 0 the prescaler phase is held at zero. After `xclk_en` rises, the first increment therefore needs a full prescale ratio of new edges.
- R5: While `xclk_en` is 0, pin edges neither change the count nor move the prescaler.
- R6: While `cnt_run` is 0 the count holds. The prescaler still tracks qualifying edges.
- R7: With `filt_sel` at 0, a pin change first sampled at rising clock edge k shows in `count` right after rising edge k+2, and not before.
- R8: With `filt_sel` = N > 0, a new pin level is accepted only after N consecutive equal synchronized samples. This adds N clocks to the R7 latency, and pin pulses shorter than N clocks are dropped.
- R9: The count steps by exactly +1 and wraps from all ones (0xFFFF at the default width of 16) to 0.
- R10: A pin whose high and low times each exceed two internal clocks, plus N when filtering, is counted on every qualifying edge. Two count steps are never in adjacent clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset; clears the count, prescaler and input pipeline |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| filt_sel | input | 4 | Filter length N; 0 means no filtering |
| psc_sel | input | 2 | Prescale code: ratio is 2 to the power of the code |
| edge_inv | input | 1 | 0 counts rising pin edges, 1 counts falling pin edges |
| xclk_en | input | 1 | Enables the external clock path |
| cnt_run | input | 1 | Counter run enable |
| count | output | CNT_W (16) | Counter value |

## Verification
The assertions take for granted that edges arrive with the pin held steady for more than two clocks. They also assume that polarity and filter settings change only while `xclk_en` is 0, so a setting change cannot look like an edge. The stimulus holds every pin level for N+3 clocks. It changes settings only after dropping `xclk_en` and waiting twenty clocks before raising it again. The one deliberate violation is a filter glitch test, where the stimulus pulse is shorter than N clocks and no count is expected.

// File: rtl/ext_edge_counter.sv
module ext_edge_counter #(
  parameter int CNT_W = 16,
  parameter int FLT_W = 4,
  parameter int PSC_W = 2,
  localparam int PH_W = (1 << PSC_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_pin,
  input  logic [FLT_W-1:0] filt_sel,
  input  logic [PSC_W-1:0] psc_sel,
  input  logic             edge_inv,
  input  logic             xclk_en,
  input  logic             cnt_run,
  output logic [CNT_W-1:0] count
);

  logic [1:0]      sync_q;
  logic            flt_q;
  logic [FLT_W-1:0] run_q;
  logic            lvl_q;
  logic [PH_W-1:0] ph_q;

  wire raw = sync_q[1];
  wire flt_off = (filt_sel == '0);
  wire lvl = (flt_off ? raw : flt_q) ^ edge_inv;
  wire hit = xclk_en & lvl & ~lvl_q;

  logic [PH_W:0] span, span_m1;
  assign span    = {{PH_W{1'b0}}, 1'b1} << psc_sel;
  assign span_m1 = span - 1'b1;
  wire tick = hit && ({1'b0, ph_q} == span_m1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], trig_pin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_q <= 1'b0;
      run_q <= '0;
    end else if (flt_off || raw == flt_q) begin
      flt_q <= raw;
      run_q <= '0;
    end else if (({1'b0, run_q} + 1'b1) >= {1'b0, filt_sel}) begin
      flt_q <= raw;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ph_q <= '0;
    else if (!xclk_en) ph_q <= '0;
    else if (hit)      ph_q <= tick ? '0 : ph_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              count <= '0;
    else if (cnt_run && tick) count <= count + 1'b1;

endmodule

module ext_edge_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xclk_en,
  input logic             cnt_run,
  input logic [CNT_W-1:0] count
);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    count != $past(count) |-> count == $past(count) + 1'b1); // R9

  AST_HOLD_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_run) |-> $stable(count)); // R6

  AST_HOLD_NO_XCLK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(xclk_en) |-> $stable(count)); // R5

  AST_SPACED_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    count != $past(count) |=> $stable(count)); // R10

endmodule

bind ext_edge_counter ext_edge_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xclk_en(xclk_en), .cnt_run(cnt_run), .count(count)
);

// File: tb/tb_ext_edge_counter.sv
module tb_ext_edge_counter;
  logic clk = 1'b0, rst_n = 1'b0, trig_pin = 1'b0;
  logic [3:0] filt_sel = '0;
  logic [1:0] psc_sel = '0;
  logic edge_inv = 1'b0, xclk_en = 1'b0, cnt_run = 1'b0;
  wire [15:0] count;
  wire [3:0]  count_n;

  always #10 clk = ~clk;

  ext_edge_counter dut (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .filt_sel(filt_sel),
    .psc_sel(psc_sel), .edge_inv(edge_inv), .xclk_en(xclk_en),
    .cnt_run(cnt_run), .count(count));

  ext_edge_counter #(.CNT_W(4)) dut_nar (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .filt_sel(filt_sel),
    .psc_sel(psc_sel), .edge_inv(edge_inv), .xclk_en(xclk_en),
    .cnt_run(cnt_run), .count(count_n));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int          q_cyc[$];
  logic [15:0] q_val[$];
  string       q_tag[$];
  logic [15:0] model = '0;
  int ph = 0;

  function automatic void expect_at(int c, logic [15:0] v, string t);
    q_cyc.push_back(c); q_val.push_back(v); q_tag.push_back(t);
  endfunction

  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      int c;
      logic [15:0] v;
      string t;
      c = q_cyc.pop_front(); v = q_val.pop_front(); t = q_tag.pop_front();
      n_chk++;
      if (c != cyc || count !== v || count_n !== v[3:0]) begin
        n_bad++;
        $display("FAIL %s: count=%h narrow=%h expected %h/%h (due cycle %0d, seen %0d)",
                 t, count, count_n, v, v[3:0], c, cyc);
      end
    end
  end

  task automatic trans(input logic lv, input string t);
    int n;
    logic q;
    logic [15:0] old;
    @(negedge clk);
    q = (lv != trig_pin) && (lv ^ edge_inv);
    n = int'(filt_sel);
    old = model;
    trig_pin = lv;
    if (q && xclk_en) begin
      ph++;
      if (ph == (1 << psc_sel)) begin
        ph = 0;
        if (cnt_run) model = model + 16'd1;
      end
    end
    expect_at(cyc + 2 + n, old, t);
    expect_at(cyc + 3 + n, model, t);
    repeat (n + 2) @(negedge clk);
  endtask

  task automatic pulses(input int k, input string t);
    for (int i = 0; i < k; i++) begin
      trans(1'b1, t);
      trans(1'b0, t);
    end
  endtask

  task automatic reconfig(input logic [3:0] f, input logic [1:0] p, input logic inv);
    @(negedge clk);
    xclk_en = 1'b0;
    filt_sel = f; psc_sel = p; edge_inv = inv;
    repeat (20) @(negedge clk);
    xclk_en = 1'b1;
    ph = 0;
    expect_at(cyc + 1, model, "R5 settle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_at(cyc + 1, 16'd0, "R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_at(cyc + 1, 16'd0, "R1 after reset");
    cnt_run = 1'b1;
    reconfig(4'd0, 2'd0, 1'b0);
    pulses(4, "R2 R7 rising");
    reconfig(4'd0, 2'd0, 1'b1);
    pulses(3, "R2 falling");
    reconfig(4'd0, 2'd1, 1'b0);
    pulses(4, "R3 div2");
    reconfig(4'd0, 2'd2, 1'b0);
    pulses(8, "R3 div4");
    reconfig(4'd0, 2'd3, 1'b0);
    pulses(16, "R3 div8");
    reconfig(4'd0, 2'd2, 1'b0);
    pulses(2, "R4 before");
    @(negedge clk); xclk_en = 1'b0;
    repeat (3) @(negedge clk); xclk_en = 1'b1; ph = 0;
    pulses(4, "R4 restart");
    reconfig(4'd0, 2'd0, 1'b0);
    @(negedge clk); xclk_en = 1'b0;
    pulses(3, "R5 disabled");
    @(negedge clk); xclk_en = 1'b1; ph = 0;
    pulses(1, "R5 re-enabled");
    @(negedge clk); cnt_run = 1'b0;
    pulses(3, "R6 halted");
    @(negedge clk); cnt_run = 1'b1;
    pulses(1, "R6 resumed");
    reconfig(4'd3, 2'd0, 1'b0);
    pulses(3, "R8 N3");
    @(negedge clk); trig_pin = 1'b1;
    repeat (2) @(negedge clk); trig_pin = 1'b0;
    expect_at(cyc + 12, model, "R8 glitch dropped");
    repeat (14) @(negedge clk);
    reconfig(4'd15, 2'd0, 1'b0);
    pulses(2, "R8 N15");
    reconfig(4'd0, 2'd0, 1'b0);
    pulses(20, "R9 R10 wrap");
    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule